// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits in front of an interrupt priority arbiter and turns one active-low external request pin into a clean request line. The pin passes through a synchronizer. A small control word, written and read over a simple register bus, then selects whether the request is taken as a low level or as a falling edge. In edge mode a detected edge is held in a pending flag until the arbiter acknowledges it or software clears it. A global disable bit blocks both the external request and a group of fixed-priority core interrupt lines that otherwise pass straight through.

While the chip is in a low-power stop or wait state, the pin is always treated as level sensitive, whatever the control word selects. This lets a held-low pin wake the chip. The block also drives a reset-vector handshake toward the core. The vector and its valid strobe stay up for the whole of reset and for the first two rising clock edges after reset is released.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Control bit 5 is the global disable. When it is 1, `ext_irq_req` is 0 and every bit of `core_irq_o` is 0. When it is 0, `core_irq_o` equals `core_irq_i`.
- R2: Control bit 0 selects the sensitivity. With 0 (level mode), `ext_irq_req` is 1 exactly while the synchronized pin is low and the disable bit is 0.
- R3: With bit 0 at 1 (edge mode), a high-to-low transition of the synchronized pin sets a pending flag, and `ext_irq_req` stays 1 until `irq_ack` or `sw_clr` is pulsed. A pin that is held low does not set the flag again.
- R4: While `lp_mode` is 1, the request is level sensitive whatever bit 0 holds. The pending flag is cleared while level sensitivity is in effect, so an edge seen before or during low-power mode is not reported after it.
- R5: Read bit 2 returns the pin level after a two-stage synchronizer (1 = pin high). Writes to bit 2 are ignored.
- R6: Read bit 4 is always 1. Read bits 3 and 1, and every bit above 5, are always 0. Writes to these bits have no effect.
- R7: While the disable bit is 1, falling edges in edge mode are still captured. When the disable bit is cleared, the held request appears on `ext_irq_req`.
- R8: A write with `wr_en` high updates bits 5 and 0 at the next rising clock edge. `rd_data` shows the current control word combinationally.
- R9: `rst_vec_valid` is 1 while `rst_n` is low and stays 1 until the second rising clock edge after `rst_n` rises, then remains 0. `rst_vec` equals the reset address while valid and is 0 otherwise.
- R10: After reset, the control word is 0 (edge select and disable both clear), the pending flag is clear, and the core interrupt lines pass through enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word write data |
| sw_clr | input | 1 | Software clear of the pending flag |
| rd_data | output | DATA_W | Composed control and status word |
| irq_pin_n | input | 1 | External active-low request pin (asynchronous) |
| lp_mode | input | 1 | Stop or wait mode indication |
| irq_ack | input | 1 | Acknowledge from the arbiter |
| core_irq_i | input | N_CORE | Fixed-priority core interrupt sources |
| core_irq_o | output | N_CORE | Core interrupt sources after global disable |
| ext_irq_req | output | 1 | Conditioned external request to the arbiter |
| rst_vec_valid | output | 1 | Reset vector valid strobe to the core |
| rst_vec | output | VEC_W | Reset vector address |

## Verification
The bench builds the block with its defaults: an 8-bit control word, four core interrupt lines, a 16-bit vector and a two-stage synchronizer. With four core lines, distinct masks such as 0xA, 0x5 and 0xF can show that gating is applied per bit. With the two-stage synchronizer, every pin change reaches the status bit and the edge detector within a fixed window of three edges, so each table step can sample after that window. The 8-bit word brings the always-zero upper bits into the read-back check.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // Field positions of the control word; the read-back layout depends on them.
  localparam int BIT_EDGE  = 0;
  localparam int BIT_ZLO   = 1;
  localparam int BIT_PIN   = 2;
  localparam int BIT_ZHI   = 3;
  localparam int BIT_ONE   = 4;
  localparam int BIT_DIS   = 5;
  localparam int CTL_MIN_W = 6;

  typedef struct packed {
    logic dis;
    logic edge_sel;
  } ctl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_nxt = d;
    end else begin : g_many
      always_comb chain_nxt = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_nxt;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic edge_sel,
  input  logic lp_mode,
  input  logic ack,
  input  logic clr,
  output logic req_raw
);
  logic prev_q, prev_nxt;
  logic pend_q, pend_nxt;
  logic use_edge;
  logic fall;

  always_comb begin
    use_edge = edge_sel & ~lp_mode;
    fall     = prev_q & ~pin_s;
    prev_nxt = pin_s;
    if (!use_edge)      pend_nxt = 1'b0;
    else if (fall)      pend_nxt = 1'b1;   // a new edge wins over a clear
    else if (ack | clr) pend_nxt = 1'b0;
    else                pend_nxt = pend_q;
    req_raw = use_edge ? pend_q : ~pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_nxt;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/ext_irq_rstvec.sv
module ext_irq_rstvec #(
  parameter int             HOLD      = 2,
  parameter int             VEC_W     = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec
);
  logic [HOLD-1:0] seen_q, seen_nxt;

  generate
    if (HOLD == 1) begin : g_one
      always_comb seen_nxt = 1'b1;
    end else begin : g_many
      always_comb seen_nxt = {seen_q[HOLD-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_nxt;
  end

  assign vec_valid = ~seen_q[HOLD-1];
  assign vec       = vec_valid ? RESET_VEC : '0;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int               DATA_W    = 8,
  parameter int               N_CORE    = 4,
  parameter int               VEC_W     = 16,
  parameter int               SYNC_N    = 2,
  parameter int               VEC_HOLD  = 2,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sw_clr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_pin_n,
  input  logic              lp_mode,
  input  logic              irq_ack,
  input  logic [N_CORE-1:0] core_irq_i,
  output logic [N_CORE-1:0] core_irq_o,
  output logic              ext_irq_req,
  output logic              rst_vec_valid,
  output logic [VEC_W-1:0]  rst_vec
);
  import ext_irq_pkg::*;

  ctl_t ctl_q, ctl_nxt;
  logic pin_s;
  logic req_raw;

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_en) begin
      ctl_nxt.dis      = wr_data[BIT_DIS];
      ctl_nxt.edge_sel = wr_data[BIT_EDGE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nxt;
  end

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_DIS]  = ctl_q.dis;
    rd_data[BIT_ONE]  = 1'b1;
    rd_data[BIT_ZHI]  = 1'b0;
    rd_data[BIT_PIN]  = pin_s;
    rd_data[BIT_ZLO]  = 1'b0;
    rd_data[BIT_EDGE] = ctl_q.edge_sel;
  end

  ext_irq_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_pin_n),
    .q     (pin_s)
  );

  ext_irq_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .edge_sel (ctl_q.edge_sel),
    .lp_mode  (lp_mode),
    .ack      (irq_ack),
    .clr      (sw_clr),
    .req_raw  (req_raw)
  );

  ext_irq_rstvec #(.HOLD(VEC_HOLD), .VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) u_rstvec (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_valid (rst_vec_valid),
    .vec       (rst_vec)
  );

  assign ext_irq_req = req_raw & ~ctl_q.dis;

  for (genvar i = 0; i < N_CORE; i++) begin : g_core
    assign core_irq_o[i] = core_irq_i[i] & ~ctl_q.dis;
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int               DATA_W    = 8,
  parameter int               N_CORE    = 4,
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'h0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              lp_mode,
  input logic [DATA_W-1:0] rd_data,
  input logic              ext_irq_req,
  input logic [N_CORE-1:0] core_irq_i,
  input logic [N_CORE-1:0] core_irq_o,
  input logic              rst_vec_valid,
  input logic [VEC_W-1:0]  rst_vec
);
  assert_disable_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] |-> (!ext_irq_req && core_irq_o == '0));

  assert_core_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[5] |-> (core_irq_o == core_irq_i));

  assert_level_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_data[0] || lp_mode) && !rd_data[5]) |-> (ext_irq_req == !rd_data[2]));

  assert_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] && !rd_data[3] && !rd_data[1]);

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[0] == $past(wr_data[0]) && rd_data[5] == $past(wr_data[5])));

  assert_vec_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_vec_valid ? (rst_vec == RESET_VEC) : (rst_vec == '0));

  assert_vec_stays_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_vec_valid |=> !rst_vec_valid);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
  .DATA_W(DATA_W), .N_CORE(N_CORE), .VEC_W(VEC_W), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .lp_mode       (lp_mode),
  .rd_data       (rd_data),
  .ext_irq_req   (ext_irq_req),
  .core_irq_i    (core_irq_i),
  .core_irq_o    (core_irq_o),
  .rst_vec_valid (rst_vec_valid),
  .rst_vec       (rst_vec)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int DATA_W = 8;
  localparam int N_CORE = 4;
  localparam int VEC_W  = 16;
  localparam logic [VEC_W-1:0] RVEC = 16'hA5C0;
  localparam int NROWS = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic sw_clr = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic irq_pin_n = 1'b1;
  logic lp_mode = 1'b0;
  logic irq_ack = 1'b0;
  logic [N_CORE-1:0] core_irq_i = 4'hA;
  logic [N_CORE-1:0] core_irq_o;
  logic ext_irq_req;
  logic rst_vec_valid;
  logic [VEC_W-1:0] rst_vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.DATA_W(DATA_W), .N_CORE(N_CORE), .VEC_W(VEC_W), .RESET_VEC(RVEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sw_clr(sw_clr),
    .rd_data(rd_data), .irq_pin_n(irq_pin_n), .lp_mode(lp_mode), .irq_ack(irq_ack),
    .core_irq_i(core_irq_i), .core_irq_o(core_irq_o), .ext_irq_req(ext_irq_req),
    .rst_vec_valid(rst_vec_valid), .rst_vec(rst_vec)
  );

  // Row: wr | wdata(8) | pin | lp | ack | clr | core(4) | exp_req | exp_rd(8) | exp_core(4)
  localparam logic [29:0] ROWS [NROWS] = '{
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'hA, 1'b0, 8'h14, 4'hA},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'hA, 1'b1, 8'h10, 4'hA},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0, 8'h14, 4'h5},
    {1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0, 8'h15, 4'h5},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 1'b1, 8'h11, 4'h5},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 1'b1, 8'h11, 4'h5},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'h5, 1'b0, 8'h11, 4'h5},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0, 8'h15, 4'h5},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 1'b1, 8'h11, 4'h5},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'h5, 1'b0, 8'h11, 4'h5},
    {1'b1, 8'h21, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 8'h35, 4'h0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 8'h31, 4'h0},
    {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 8'h11, 4'hF},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 8'h15, 4'hF},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 4'hA, 1'b0, 8'h15, 4'hA},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'hA, 1'b1, 8'h11, 4'hA},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'hA, 1'b0, 8'h11, 4'hA},
    {1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 4'hA, 1'b0, 8'h35, 4'h0},
    {1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'hA, 1'b0, 8'h14, 4'hA}
  };

  localparam string TAGS [NROWS] = '{
    "R2", "R2", "R5", "R8", "R3", "R3", "R3", "R3", "R3", "R3",
    "R1", "R7", "R7", "R3", "R4", "R4", "R4", "R6", "R6"
  };

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply_row(input logic [29:0] r);
    @(negedge clk);
    wr_en      = r[29];
    wr_data    = r[28:21];
    irq_pin_n  = r[20];
    lp_mode    = r[19];
    irq_ack    = r[18];
    sw_clr     = r[17];
    core_irq_i = r[16:13];
    @(negedge clk);
    wr_en   = 1'b0;
    irq_ack = 1'b0;
    sw_clr  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: vector presented during reset and for two edges after release
    repeat (3) @(negedge clk);
    check("R9", "valid in reset", 32'(rst_vec_valid), 32'd1);
    check("R9", "vector in reset", 32'(rst_vec), 32'(RVEC));
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "valid after 1st edge", 32'(rst_vec_valid), 32'd1);
    @(negedge clk);
    check("R9", "valid after 2nd edge", 32'(rst_vec_valid), 32'd0);
    check("R9", "vector dropped", 32'(rst_vec), 32'd0);
    repeat (3) @(negedge clk);
    check("R9", "valid stays low", 32'(rst_vec_valid), 32'd0);

    // R10: defaults after reset
    check("R10", "rd_data default", 32'(rd_data), 32'h14);
    check("R10", "ext_irq_req default", 32'(ext_irq_req), 32'd0);
    check("R10", "core passthrough", 32'(core_irq_o), 32'hA);

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      apply_row(ROWS[i]);
      check(TAGS[i], $sformatf("row %0d ext_irq_req", i), 32'(ext_irq_req), 32'(ROWS[i][12]));
      check(TAGS[i], $sformatf("row %0d rd_data", i), 32'(rd_data), 32'(ROWS[i][11:4]));
      check(TAGS[i], $sformatf("row %0d core_irq_o", i), 32'(core_irq_o), 32'(ROWS[i][3:0]));
    end

    // R8: write lands on the clock edge, not before
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h20;
    #1;
    check("R8", "before edge", 32'(rd_data), 32'h14);
    @(negedge clk);
    wr_en = 1'b0;
    check("R8", "after edge", 32'(rd_data), 32'h34);
    check("R1", "core blocked", 32'(core_irq_o), 32'h0);

    // R1: disable holds a low level pin off the request
    irq_pin_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "level blocked", 32'(ext_irq_req), 32'd0);
    wr_en = 1'b1;
    wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2", "level after enable", 32'(ext_irq_req), 32'd1);

    // R10: mid-run reset restores defaults and the vector handshake
    irq_pin_n = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R9", "valid on reassert", 32'(rst_vec_valid), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "rd_data after reset", 32'(rd_data), 32'h14);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule